// File: doc/BRIEF.md
# Shared Prescaler and Divider Tick Mux

This block generates one tick-enable pulse per channel for a five-channel timer. A system tick enable (`base_en`) feeds two 8-bit prescalers. The first prescaler serves channels 0 and 1, and the second serves channels 2, 3 and 4. Each channel has a 4-bit selector code. The code either divides its group's prescaled tick by a further power of two, or routes one of two external tick inputs straight through.

Software programs the block through a write-only port that holds two configuration words. Timer channels use each `ch_tick` bit as a count enable. All logic runs on `clk`. The external ticks must already be synchronous to it.

The block has no state machine. Each channel's source kind is an enumerated decode with two values. `SRC_DIVIDED` takes the divided prescaler tick. `SRC_EXTERNAL` takes the external input for the channel's group.

Top module: `tick_divider_mux`

## Requirements
- R1: Reset sets both prescale values and all channel codes to zero, and holds `ch_tick` low. With `base_en` held high after reset and `DIV_BASE`=0, every channel ticks on every cycle.
- R2: A write to offset 0x00 loads prescale value A from `wr_data[7:0]` and prescale value B from `wr_data[15:8]`. A prescale value p produces one prescaled tick for every p+1 cycles in which `base_en` is high.
- R3: Channels 0 and 1 count on prescaler A. Channels 2, 3 and 4 count on prescaler B.
- R4: A write to offset 0x04 loads the code of channel n from `wr_data[4n+3:4n]`. A divide code m gives one channel tick for every 2^(m+`DIV_BASE`) prescaled ticks of the channel's group.
- R5: A code whose bit is set in `EXT_CODES` selects an external tick. The default set is codes 5, 6 and 7. Channels 0 and 1 follow `ext_tick[0]`, and channels 2 to 4 follow `ext_tick[1]`, one cycle later, whatever the value of `base_en`.
- R6: A code above 4 that is not an external code divides exactly like code 4.
- R7: A write to 0x00 or 0x04 clears every prescaler and divider counter. It also forces all `ch_tick` bits low in the following cycle.
- R8: A write to any other offset changes neither the configuration nor the counters.
- R9: A divided tick appears on `ch_tick` in the cycle after the `base_en` cycle that completes its count. Each divided tick is high for a single cycle.
- R10: While `base_en` is low, the prescaler counters hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_en | input | 1 | System tick enable that feeds both prescalers |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 20 | Write data |
| ext_tick | input | 2 | External ticks: bit 0 for channels 0 and 1, bit 1 for channels 2 to 4 |
| ch_tick | output | 5 | Per-channel tick enable |

## Verification
The assertions check several properties on every cycle:
- each prescaler counter stays at or below its limit;
- a configuration write clears the counters and silences the outputs;
- the counters freeze while `base_en` is low;
- an external-source channel repeats its input one cycle later;
- a divided tick is always preceded by a prescaled tick.

Only the bench scenarios can show the exact tick rates. These cover the p+1 and 2^m ratios, the mapping of channels to groups, the clamping of unused codes, and the fact that writes to foreign offsets leave nothing disturbed.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [0:0] {
        SRC_DIVIDED  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } src_kind_e;

    localparam int NUM_GROUPS = 2;
endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs #(
    parameter int NUM_CH   = 5,
    parameter int PRE_W    = 8,
    parameter int MUX_W    = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 20,
    parameter logic [ADDR_W-1:0] PRE_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0] MUX_ADDR = 8'h04
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [2*PRE_W-1:0]          pre_vals,
    output logic [NUM_CH*MUX_W-1:0]     mux_codes,
    output logic                        restart
);
    localparam int PRE_BITS = 2 * PRE_W;
    localparam int MUX_BITS = NUM_CH * MUX_W;

    logic hit_pre;
    logic hit_mux;

    assign hit_pre = wr_en && (wr_addr == PRE_ADDR);
    assign hit_mux = wr_en && (wr_addr == MUX_ADDR);
    assign restart = hit_pre || hit_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_vals  <= '0;
            mux_codes <= '0;
        end else begin
            if (hit_pre) pre_vals  <= wr_data[PRE_BITS-1:0];
            if (hit_mux) mux_codes <= wr_data[MUX_BITS-1:0];
        end
    end
endmodule

// File: rtl/tdm_prescaler.sv
module tdm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             pre_tick
);
    logic [PRE_W-1:0] cnt;
    logic             at_limit;

    assign at_limit = (cnt == limit);
    assign pre_tick = base_en && at_limit && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (base_en) begin
            cnt <= at_limit ? '0 : cnt + 1'b1;
        end
    end

    // R2: the counter never passes its limit
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);

    // R7: a configuration write clears the counter
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R10: counter holds without the base enable
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_en && !restart) |=> $stable(cnt));
endmodule

// File: rtl/tdm_chan_div.sv
module tdm_chan_div
    import tdm_pkg::*;
#(
    parameter int MUX_W    = 4,
    parameter int DIV_BASE = 0,
    parameter int MAX_CODE = 4,
    parameter logic [(2**MUX_W)-1:0] EXT_CODES = 16'h00E0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic             ext_in,
    input  logic [MUX_W-1:0] code,
    output logic             tick
);
    localparam int DIVW = (MAX_CODE + DIV_BASE > 0) ? (MAX_CODE + DIV_BASE) : 1;

    src_kind_e        src;
    logic [DIVW-1:0]  div_cnt;
    logic [DIVW-1:0]  mask;
    logic             div_hit;
    logic             nxt;
    int               shift;

    assign src = EXT_CODES[code] ? SRC_EXTERNAL : SRC_DIVIDED;

    always_comb begin
        shift = ((int'(code) > MAX_CODE) ? MAX_CODE : int'(code)) + DIV_BASE;
        for (int i = 0; i < DIVW; i++) begin
            mask[i] = (i < shift);
        end
    end

    assign div_hit = pre_tick && ((div_cnt & mask) == mask);

    always_comb begin
        unique case (src)
            SRC_EXTERNAL: nxt = ext_in;
            SRC_DIVIDED:  nxt = div_hit;
            default:      nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart) begin
            div_cnt <= '0;
        end else if (pre_tick) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= restart ? 1'b0 : nxt;
    end

    // R5: an external source reappears one cycle later
    assert_ext_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXTERNAL && !$past(restart)) |-> (tick == $past(ext_in)));

    // R9: a divided tick is always preceded by a prescaled tick
    assert_div_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_DIVIDED && tick) |-> $past(pre_tick));

    // R7: the divider restarts on a configuration write
    assert_div_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_cnt == '0));
endmodule

// File: rtl/tick_divider_mux.sv
module tick_divider_mux #(
    parameter int NUM_CH   = 5,
    parameter int GRP0_CH  = 2,
    parameter int PRE_W    = 8,
    parameter int MUX_W    = 4,
    parameter int DIV_BASE = 0,
    parameter int MAX_CODE = 4,
    parameter logic [(2**MUX_W)-1:0] EXT_CODES = 16'h00E0,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = ((2 * PRE_W) > (NUM_CH * MUX_W)) ? (2 * PRE_W) : (NUM_CH * MUX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        ext_tick,
    output logic [NUM_CH-1:0] ch_tick
);
    import tdm_pkg::*;

    logic [2*PRE_W-1:0]      pre_vals;
    logic [NUM_CH*MUX_W-1:0] mux_codes;
    logic                    restart;
    logic [NUM_GROUPS-1:0]   grp_tick;

    tdm_cfg_regs #(
        .NUM_CH (NUM_CH),
        .PRE_W  (PRE_W),
        .MUX_W  (MUX_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pre_vals  (pre_vals),
        .mux_codes (mux_codes),
        .restart   (restart)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pre
        tdm_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_en  (base_en),
            .restart  (restart),
            .limit    (pre_vals[g*PRE_W +: PRE_W]),
            .pre_tick (grp_tick[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;
        tdm_chan_div #(
            .MUX_W     (MUX_W),
            .DIV_BASE  (DIV_BASE),
            .MAX_CODE  (MAX_CODE),
            .EXT_CODES (EXT_CODES)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .pre_tick (grp_tick[GRP]),
            .ext_in   (ext_tick[GRP]),
            .code     (mux_codes[c*MUX_W +: MUX_W]),
            .tick     (ch_tick[c])
        );
    end

    // R7: outputs stay silent in the cycle after a configuration write
    assert_quiet_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ch_tick == '0));
endmodule

// File: tb/tick_divider_mux_test.sv
module tick_divider_mux_test;
    localparam int BASE = 0;
    localparam logic [15:0] EXTS = 16'h00E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic [1:0]  ext_tick = '0;
    logic [4:0]  ch_tick;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    logic running = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    tick_divider_mux uut (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ext_tick(ext_tick), .ch_tick(ch_tick)
    );

    // behavioural reference model
    int m_pc [2];
    int m_p [2];
    int m_dc [5];
    logic [19:0] m_mux;
    logic [4:0] exp_tick;
    logic m_restart;
    logic [1:0] m_pt;
    int code, e, n, g;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin m_pc[i] = 0; m_p[i] = 0; end
            for (int i = 0; i < 5; i++) m_dc[i] = 0;
            m_mux = '0;
            exp_tick = '0;
        end else begin
            m_restart = wr_en && (wr_addr == 8'h00 || wr_addr == 8'h04);
            for (int i = 0; i < 2; i++)
                m_pt[i] = base_en && (m_pc[i] == m_p[i]) && !m_restart;
            for (int c = 0; c < 5; c++) begin
                g = (c < 2) ? 0 : 1;
                code = int'(m_mux[4*c +: 4]);
                if (EXTS[code]) begin
                    exp_tick[c] = ext_tick[g];
                end else begin
                    e = ((code > 4) ? 4 : code) + BASE;
                    n = 1 << e;
                    exp_tick[c] = m_pt[g] && ((m_dc[c] % n) == n - 1);
                end
                if (m_restart) exp_tick[c] = 1'b0;
            end
            if (m_restart) begin
                for (int i = 0; i < 2; i++) m_pc[i] = 0;
                for (int i = 0; i < 5; i++) m_dc[i] = 0;
                if (wr_addr == 8'h00) begin
                    m_p[0] = int'(wr_data[7:0]);
                    m_p[1] = int'(wr_data[15:8]);
                end else begin
                    m_mux = wr_data;
                end
            end else begin
                for (int i = 0; i < 2; i++)
                    if (base_en) m_pc[i] = (m_pc[i] == m_p[i]) ? 0 : m_pc[i] + 1;
                for (int c = 0; c < 5; c++)
                    if (m_pt[(c < 2) ? 0 : 1]) m_dc[c] = (m_dc[c] + 1) % 32;
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            checks++;
            if (ch_tick !== exp_tick) begin
                fails++;
                $display("FAIL %s: ch_tick=%b expected %b at %0t", phase, ch_tick, exp_tick, $time);
            end
        end
    end

    task automatic write_cfg(input logic [7:0] a, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_random(input int cycles, input bit rnd_en, input bit rnd_ext);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            base_en = rnd_en ? lfsr[0] : 1'b1;
            if (rnd_ext) ext_tick = lfsr[3:2];
        end
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        checks++;
        if (ch_tick !== 5'b0) begin
            fails++;
            $display("FAIL R1: ch_tick=%b expected 00000 in reset", ch_tick);
        end
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;

        phase = "R1";
        run_random(20, 0, 0);

        phase = "R2";
        write_cfg(8'h00, 20'h00302);
        write_cfg(8'h04, 20'h43210);
        run_random(400, 0, 0);

        phase = "R3";
        write_cfg(8'h00, 20'h00500);
        run_random(300, 0, 0);

        phase = "R4";
        write_cfg(8'h00, 20'h00000);
        write_cfg(8'h04, 20'h01234);
        run_random(200, 0, 0);

        phase = "R10";
        write_cfg(8'h00, 20'h00201);
        run_random(600, 1, 0);

        phase = "R5";
        write_cfg(8'h04, 20'h07165);
        run_random(300, 1, 1);

        phase = "R6";
        write_cfg(8'h04, 20'h9F8C4);
        run_random(400, 1, 0);

        phase = "R8";
        write_cfg(8'h08, 20'hFFFFF);
        run_random(50, 1, 1);
        write_cfg(8'h05, 20'h00000);
        run_random(100, 0, 1);

        phase = "R7";
        for (int k = 0; k < 10; k++) begin
            write_cfg(8'h00, {12'h0, 4'(k), 4'(k + 1)});
            run_random(k + 3, 1, 1);
        end
        write_cfg(8'h04, 20'h00000);
        run_random(30, 0, 0);

        phase = "R9";
        base_en = 1'b0;
        write_cfg(8'h00, 20'h00001);
        write_cfg(8'h04, 20'h00001);
        cnt = 0;
        for (int i = 0; i < 43; i++) begin
            @(negedge clk);
            cnt += int'(ch_tick[0]);
            base_en = (i < 40);
        end
        checks++;
        if (cnt != 10) begin
            fails++;
            $display("FAIL R9: ch0 tick count=%0d expected 10", cnt);
        end

        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: cycles=150000 expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule